// File: doc/BRIEF.md
# Quadratic Switching-Surface Evaluator

This block is the per-sample arithmetic core of a state-feedback controller for a synchronous boost converter. On every sample strobe it takes the digitized inductor current and capacitor voltage, the input-voltage sample, the equilibrium target (current and voltage) and the control bit that is driving the power switch. It then evaluates two hysteresis surfaces, one for the switch-on topology and one for the switch-off topology. Each surface is a quadratic form in the state error: the error weighted against the topology's state derivative, plus a positive penalty on the error. The block reports both surface values. It also reports a one-bit flag that tells whether the surface of the topology now in use is negative. The commutation logic that sits downstream uses this flag.

All arithmetic is signed fixed point. The state and the results carry `XF` fractional bits and the gains carry `GF` fractional bits. Every circuit and weighting constant is a parameter that is computed off line, scaled by the sample period and pre-inverted, so no division happens at run time. Every intermediate is clamped to the `DW`-bit range. The evaluation is a three-register pipeline, so a new sample may arrive on every clock. This is far inside the budget of one sample period at a sample rate in the low megahertz.

Top module: `qse_top`

## Requirements
- R1: While the synchronous reset is high, and after it until the first result, `res_vld_o` and `neg_flag_o` are 0 and `s_on_o` and `s_off_o` are 0.
- R2: If `smp_stb_i` is high at rising edge n, `res_vld_o` is high in the cycle between edges n+2 and n+3. In all other cycles it is low.
- R3: The flow terms are computed from the signed `DW`-bit inputs with gains in Q`GF`, where `>>>` is a flooring arithmetic shift and sat is the clamp of R7. They are fi_on = sat((K_INV_L*vin - K_RL_L*iL) >>> GF), fv_on = sat((-K_LOAD*vC) >>> GF), fi_off = sat((K_INV_L*vin - K_RL_L*iL - K_INV_L*vC) >>> GF) and fv_off = sat((K_INV_C*iL - K_LOAD*vC) >>> GF).
- R4: For each topology the block forms gi = sat((P_AL*fi + P_BE*fv) >>> GF) and gv = sat((P_BE*fi + P_GA*fv) >>> GF). The surface is sat(((ei*gi + ev*gv) >>> XF) + pen), where ei = iL - IE and ev = vC - VE. `s_on_o` carries the surface built from the on-topology terms.
- R5: `s_off_o` carries the surface built from the off-topology terms. Both surfaces are produced for every sample, whatever the control bit is.
- R6: The penalty is pen = sat((K_QI*ei*ei + K_QV*ev*ev) >>> (GF+XF)) and is shared by both surfaces. With iL = vC = vin = 0, both outputs equal pen, and pen is never negative.
- R7: Each sat clamps to the range -2^(DW-1) to 2^(DW-1)-1. Full-scale inputs give clamped results and never wrapped ones.
- R8: `neg_flag_o` is 1 exactly when the selected surface is negative. If the control bit sampled with the strobe is 1, the selected surface is `s_on_o`; otherwise it is `s_off_o`.
- R9: In a cycle without `res_vld_o`, `s_on_o`, `s_off_o` and `neg_flag_o` keep their previous values.
- R10: Strobes on consecutive clocks each yield their own result, in order, on consecutive cycles.
- R11: When the state equals the target (iL = IE, vC = VE), both surfaces are 0 and the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb_i | input | 1 | A new sample is present on the data inputs |
| sw_on_i | input | 1 | Control bit in use: 1 for the switch-on topology |
| il_i | input | DW | Inductor current, signed Q`XF` |
| vc_i | input | DW | Capacitor voltage, signed Q`XF` |
| vin_i | input | DW | Input voltage, signed Q`XF` |
| il_ref_i | input | DW | Equilibrium current target IE |
| vc_ref_i | input | DW | Equilibrium voltage target VE |
| res_vld_o | output | 1 | Result strobe, two cycles after the sample strobe |
| neg_flag_o | output | 1 | Surface of the active topology is negative |
| s_on_o | output | DW | On-topology surface value |
| s_off_o | output | DW | Off-topology surface value |

## Verification
The hardest situation to reach is an intermediate term that saturates while the final surface still lands inside the range. Random state samples almost never produce the corner where the flow term clips but its weighted product does not. The stimulus therefore mixes random samples in a mid range with directed full-scale and opposite-sign extremes. It also includes a sample with zero state and nonzero error, which isolates the penalty, and a sample at exactly the target. Each directed sample is applied with both control-bit values, so that the flag selection is seen on the same pair of surfaces.

// File: rtl/qse_pkg.sv
package qse_pkg;

  typedef enum logic {
    TOPO_OFF = 1'b0,
    TOPO_ON  = 1'b1
  } topo_e;

  localparam int unsigned N_TOPO = 2;

  // Clamp a wide signed value into a w-bit signed range.
  function automatic logic signed [63:0] clamp_w(input logic signed [63:0] v,
                                                 input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/qse_front.sv
module qse_front #(
  parameter int DW      = 16,
  parameter int GF      = 16,
  parameter int K_RL_L  = 500,
  parameter int K_INV_L = 20000,
  parameter int K_INV_C = 30000,
  parameter int K_LOAD  = 3000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb,
  input  logic                 u_in,
  input  logic signed [DW-1:0] il,
  input  logic signed [DW-1:0] vc,
  input  logic signed [DW-1:0] vin,
  input  logic signed [DW-1:0] ie,
  input  logic signed [DW-1:0] ve,
  output logic                 v1,
  output logic                 u1,
  output logic signed [DW:0]   ei,
  output logic signed [DW:0]   ev,
  output logic signed [DW-1:0] fi_on,
  output logic signed [DW-1:0] fv_on,
  output logic signed [DW-1:0] fi_off,
  output logic signed [DW-1:0] fv_off
);
  import qse_pkg::*;

  localparam logic signed [63:0] KA = 64'(K_RL_L);
  localparam logic signed [63:0] KB = 64'(K_INV_L);
  localparam logic signed [63:0] KC = 64'(K_INV_C);
  localparam logic signed [63:0] KD = 64'(K_LOAD);

  logic signed [63:0] il64, vc64, vin64;
  logic signed [63:0] t_src;
  logic signed [DW:0] ei_n, ev_n;
  logic signed [DW-1:0] fi_on_n, fv_on_n, fi_off_n, fv_off_n;

  always_comb begin
    il64  = 64'(il);
    vc64  = 64'(vc);
    vin64 = 64'(vin);
    t_src = KB * vin64 - KA * il64;
    ei_n  = (DW+1)'(il) - (DW+1)'(ie);
    ev_n  = (DW+1)'(vc) - (DW+1)'(ve);
    fi_on_n  = DW'(clamp_w(t_src >>> GF, DW));
    fv_on_n  = DW'(clamp_w((-(KD * vc64)) >>> GF, DW));
    fi_off_n = DW'(clamp_w((t_src - KB * vc64) >>> GF, DW));
    fv_off_n = DW'(clamp_w((KC * il64 - KD * vc64) >>> GF, DW));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      u1     <= 1'b0;
      ei     <= '0;
      ev     <= '0;
      fi_on  <= '0;
      fv_on  <= '0;
      fi_off <= '0;
      fv_off <= '0;
    end else begin
      v1 <= stb;
      if (stb) begin
        u1     <= u_in;
        ei     <= ei_n;
        ev     <= ev_n;
        fi_on  <= fi_on_n;
        fv_on  <= fv_on_n;
        fi_off <= fi_off_n;
        fv_off <= fv_off_n;
      end
    end
  end

endmodule

// File: rtl/qse_shape.sv
module qse_shape #(
  parameter int DW    = 16,
  parameter int GF    = 16,
  parameter int XF    = 8,
  parameter int P_AL  = 151441,
  parameter int P_BE  = -636,
  parameter int P_GA  = 65543,
  parameter int K_QI  = 200,
  parameter int K_QV  = 400
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v1,
  input  logic                 u1,
  input  logic signed [DW:0]   ei,
  input  logic signed [DW:0]   ev,
  input  logic signed [DW-1:0] fi_on,
  input  logic signed [DW-1:0] fv_on,
  input  logic signed [DW-1:0] fi_off,
  input  logic signed [DW-1:0] fv_off,
  output logic                 v2,
  output logic                 u2,
  output logic signed [DW:0]   ei2,
  output logic signed [DW:0]   ev2,
  output logic signed [DW-1:0] gi_on,
  output logic signed [DW-1:0] gv_on,
  output logic signed [DW-1:0] gi_off,
  output logic signed [DW-1:0] gv_off,
  output logic signed [DW-1:0] pen
);
  import qse_pkg::*;

  localparam logic signed [63:0] PA = 64'(P_AL);
  localparam logic signed [63:0] PB = 64'(P_BE);
  localparam logic signed [63:0] PC = 64'(P_GA);
  localparam logic signed [63:0] QI = 64'(K_QI);
  localparam logic signed [63:0] QV = 64'(K_QV);
  localparam int unsigned PEN_SH = GF + XF;

  logic signed [DW-1:0] fi_a [N_TOPO];
  logic signed [DW-1:0] fv_a [N_TOPO];
  logic signed [DW-1:0] gi_n [N_TOPO];
  logic signed [DW-1:0] gv_n [N_TOPO];
  logic signed [DW-1:0] gi_q [N_TOPO];
  logic signed [DW-1:0] gv_q [N_TOPO];
  logic signed [63:0]   ei64, ev64;
  logic signed [DW-1:0] pen_n;

  assign fi_a[TOPO_OFF] = fi_off;
  assign fv_a[TOPO_OFF] = fv_off;
  assign fi_a[TOPO_ON]  = fi_on;
  assign fv_a[TOPO_ON]  = fv_on;

  for (genvar t = 0; t < N_TOPO; t++) begin : g_topo
    logic signed [63:0] fi64, fv64;
    always_comb begin
      fi64    = 64'(fi_a[t]);
      fv64    = 64'(fv_a[t]);
      gi_n[t] = DW'(clamp_w((PA * fi64 + PB * fv64) >>> GF, DW));
      gv_n[t] = DW'(clamp_w((PB * fi64 + PC * fv64) >>> GF, DW));
    end
  end

  always_comb begin
    ei64  = 64'(ei);
    ev64  = 64'(ev);
    pen_n = DW'(clamp_w((QI * ei64 * ei64 + QV * ev64 * ev64) >>> PEN_SH, DW));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2  <= 1'b0;
      u2  <= 1'b0;
      ei2 <= '0;
      ev2 <= '0;
      pen <= '0;
      for (int t = 0; t < N_TOPO; t++) begin
        gi_q[t] <= '0;
        gv_q[t] <= '0;
      end
    end else begin
      v2 <= v1;
      if (v1) begin
        u2  <= u1;
        ei2 <= ei;
        ev2 <= ev;
        pen <= pen_n;
        for (int t = 0; t < N_TOPO; t++) begin
          gi_q[t] <= gi_n[t];
          gv_q[t] <= gv_n[t];
        end
      end
    end
  end

  assign gi_on  = gi_q[TOPO_ON];
  assign gv_on  = gv_q[TOPO_ON];
  assign gi_off = gi_q[TOPO_OFF];
  assign gv_off = gv_q[TOPO_OFF];

  if (K_QI >= 0 && K_QV >= 0) begin : g_pen_chk
    AST_PEN_NONNEG: assert property (@(posedge clk) disable iff (rst)
      v2 |-> !pen[DW-1]); // R6
  end

endmodule

// File: rtl/qse_combine.sv
module qse_combine #(
  parameter int DW = 16,
  parameter int XF = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v2,
  input  logic                 u2,
  input  logic signed [DW:0]   ei2,
  input  logic signed [DW:0]   ev2,
  input  logic signed [DW-1:0] gi_on,
  input  logic signed [DW-1:0] gv_on,
  input  logic signed [DW-1:0] gi_off,
  input  logic signed [DW-1:0] gv_off,
  input  logic signed [DW-1:0] pen,
  output logic                 vld,
  output logic                 flag,
  output logic signed [DW-1:0] s_on,
  output logic signed [DW-1:0] s_off
);
  import qse_pkg::*;

  logic signed [DW-1:0] gi_a [N_TOPO];
  logic signed [DW-1:0] gv_a [N_TOPO];
  logic signed [DW-1:0] s_n  [N_TOPO];
  logic signed [DW-1:0] s_q  [N_TOPO];
  logic signed [63:0]   ei64, ev64, pen64;
  logic                 flag_n;
  logic                 u3;

  assign gi_a[TOPO_OFF] = gi_off;
  assign gv_a[TOPO_OFF] = gv_off;
  assign gi_a[TOPO_ON]  = gi_on;
  assign gv_a[TOPO_ON]  = gv_on;

  always_comb begin
    ei64  = 64'(ei2);
    ev64  = 64'(ev2);
    pen64 = 64'(pen);
  end

  for (genvar t = 0; t < N_TOPO; t++) begin : g_surf
    always_comb begin
      s_n[t] = DW'(clamp_w(((ei64 * 64'(gi_a[t]) + ev64 * 64'(gv_a[t])) >>> XF) + pen64, DW));
    end
  end

  always_comb begin
    if (topo_e'(u2) == TOPO_ON) flag_n = s_n[TOPO_ON][DW-1];
    else                        flag_n = s_n[TOPO_OFF][DW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      flag <= 1'b0;
      u3   <= 1'b0;
      for (int t = 0; t < N_TOPO; t++) s_q[t] <= '0;
    end else begin
      vld <= v2;
      if (v2) begin
        flag <= flag_n;
        u3   <= u2;
        for (int t = 0; t < N_TOPO; t++) s_q[t] <= s_n[t];
      end
    end
  end

  assign s_on  = s_q[TOPO_ON];
  assign s_off = s_q[TOPO_OFF];

  AST_FLAG_SIGN: assert property (@(posedge clk) disable iff (rst)
    vld |-> (flag == (u3 ? s_q[TOPO_ON][DW-1] : s_q[TOPO_OFF][DW-1]))); // R8

endmodule

// File: rtl/qse_top.sv
module qse_top #(
  parameter int DW      = 16,
  parameter int XF      = 8,
  parameter int GF      = 16,
  parameter int K_RL_L  = 500,
  parameter int K_INV_L = 20000,
  parameter int K_INV_C = 30000,
  parameter int K_LOAD  = 3000,
  parameter int P_AL    = 151441,
  parameter int P_BE    = -636,
  parameter int P_GA    = 65543,
  parameter int K_QI    = 200,
  parameter int K_QV    = 400
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb_i,
  input  logic                 sw_on_i,
  input  logic signed [DW-1:0] il_i,
  input  logic signed [DW-1:0] vc_i,
  input  logic signed [DW-1:0] vin_i,
  input  logic signed [DW-1:0] il_ref_i,
  input  logic signed [DW-1:0] vc_ref_i,
  output logic                 res_vld_o,
  output logic                 neg_flag_o,
  output logic signed [DW-1:0] s_on_o,
  output logic signed [DW-1:0] s_off_o
);

  logic                 v1, u1, v2, u2;
  logic signed [DW:0]   ei, ev, ei2, ev2;
  logic signed [DW-1:0] fi_on, fv_on, fi_off, fv_off;
  logic signed [DW-1:0] gi_on, gv_on, gi_off, gv_off, pen;

  qse_front #(
    .DW(DW), .GF(GF), .K_RL_L(K_RL_L), .K_INV_L(K_INV_L),
    .K_INV_C(K_INV_C), .K_LOAD(K_LOAD)
  ) u_front (
    .clk(clk), .rst(rst), .stb(smp_stb_i), .u_in(sw_on_i),
    .il(il_i), .vc(vc_i), .vin(vin_i), .ie(il_ref_i), .ve(vc_ref_i),
    .v1(v1), .u1(u1), .ei(ei), .ev(ev),
    .fi_on(fi_on), .fv_on(fv_on), .fi_off(fi_off), .fv_off(fv_off)
  );

  qse_shape #(
    .DW(DW), .GF(GF), .XF(XF), .P_AL(P_AL), .P_BE(P_BE), .P_GA(P_GA),
    .K_QI(K_QI), .K_QV(K_QV)
  ) u_shape (
    .clk(clk), .rst(rst), .v1(v1), .u1(u1), .ei(ei), .ev(ev),
    .fi_on(fi_on), .fv_on(fv_on), .fi_off(fi_off), .fv_off(fv_off),
    .v2(v2), .u2(u2), .ei2(ei2), .ev2(ev2),
    .gi_on(gi_on), .gv_on(gv_on), .gi_off(gi_off), .gv_off(gv_off), .pen(pen)
  );

  qse_combine #(
    .DW(DW), .XF(XF)
  ) u_comb (
    .clk(clk), .rst(rst), .v2(v2), .u2(u2), .ei2(ei2), .ev2(ev2),
    .gi_on(gi_on), .gv_on(gv_on), .gi_off(gi_off), .gv_off(gv_off), .pen(pen),
    .vld(res_vld_o), .flag(neg_flag_o), .s_on(s_on_o), .s_off(s_off_o)
  );

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    res_vld_o |-> $past(smp_stb_i, 3)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_vld_o |-> ($stable(s_on_o) && $stable(s_off_o) && $stable(neg_flag_o))); // R9

endmodule

// File: tb/sim_qse_top.sv
module sim_qse_top;
  localparam int CLK_NS  = 10;
  localparam int DW      = 16;
  localparam int XF      = 8;
  localparam int GF      = 16;
  localparam longint KA  = 500;
  localparam longint KB  = 20000;
  localparam longint KC  = 30000;
  localparam longint KD  = 3000;
  localparam longint PA  = 151441;
  localparam longint PB  = -636;
  localparam longint PC  = 65543;
  localparam longint QI  = 200;
  localparam longint QV  = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic sw  = 1'b0;
  logic signed [DW-1:0] il = '0, vc = '0, vin = '0, ie = '0, ve = '0;
  logic                 vld, flag;
  logic signed [DW-1:0] s_on, s_off;

  qse_top #(
    .DW(DW), .XF(XF), .GF(GF), .K_RL_L(int'(KA)), .K_INV_L(int'(KB)),
    .K_INV_C(int'(KC)), .K_LOAD(int'(KD)), .P_AL(int'(PA)), .P_BE(int'(PB)),
    .P_GA(int'(PC)), .K_QI(int'(QI)), .K_QV(int'(QV))
  ) u0 (
    .clk(clk), .rst(rst), .smp_stb_i(stb), .sw_on_i(sw),
    .il_i(il), .vc_i(vc), .vin_i(vin), .il_ref_i(ie), .vc_ref_i(ve),
    .res_vld_o(vld), .neg_flag_o(flag), .s_on_o(s_on), .s_off_o(s_off)
  );

  always #(CLK_NS/2) clk = ~clk;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  bit     pv [3];
  longint p1 [3];
  longint p0 [3];
  bit     pf [3];
  string  pt [3];
  longint last1 = 0, last0 = 0;
  bit     lastf = 1'b0;

  function automatic longint sat(input longint v);
    longint hi = (longint'(1) <<< (DW - 1)) - 1;
    longint lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic void model(input longint xi, input longint xv, input longint xin,
                                input longint ri, input longint rv, input bit uu,
                                output longint s1, output longint s0, output bit f);
    longint ei = xi - ri;
    longint ev = xv - rv;
    longint fi1 = sat((KB * xin - KA * xi) >>> GF);
    longint fv1 = sat((-(KD * xv)) >>> GF);
    longint fi0 = sat((KB * xin - KA * xi - KB * xv) >>> GF);
    longint fv0 = sat((KC * xi - KD * xv) >>> GF);
    longint gi1 = sat((PA * fi1 + PB * fv1) >>> GF);
    longint gv1 = sat((PB * fi1 + PC * fv1) >>> GF);
    longint gi0 = sat((PA * fi0 + PB * fv0) >>> GF);
    longint gv0 = sat((PB * fi0 + PC * fv0) >>> GF);
    longint pen = sat((QI * ei * ei + QV * ev * ev) >>> (GF + XF));
    s1 = sat(((ei * gi1 + ev * gv1) >>> XF) + pen);
    s0 = sat(((ei * gi0 + ev * gv0) >>> XF) + pen);
    f  = uu ? (s1 < 0) : (s0 < 0);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock per call: check what is due now, then drive the next inputs.
  task automatic step(input bit s, input bit uu, input longint xi, input longint xv,
                      input longint xin, input longint ri, input longint rv,
                      input string tag);
    longint e1, e0;
    bit     ef;
    @(negedge clk);
    chk(vld == pv[2], {"R2 valid ", pt[2]}, longint'(vld), longint'(pv[2]));
    if (pv[2]) begin
      chk(longint'(s_on) == p1[2], {"R3/R4 s_on ", pt[2]}, longint'(s_on), p1[2]);
      chk(longint'(s_off) == p0[2], {"R5 s_off ", pt[2]}, longint'(s_off), p0[2]);
      chk(flag == pf[2], {"R8 flag ", pt[2]}, longint'(flag), longint'(pf[2]));
      last1 = p1[2]; last0 = p0[2]; lastf = pf[2];
    end else begin
      chk(longint'(s_on) == last1 && longint'(s_off) == last0 && flag == lastf,
          "R9 hold", longint'(s_on), last1);
    end
    for (int k = 2; k > 0; k--) begin
      pv[k] = pv[k-1]; p1[k] = p1[k-1]; p0[k] = p0[k-1]; pf[k] = pf[k-1]; pt[k] = pt[k-1];
    end
    model(xi, xv, xin, ri, rv, uu, e1, e0, ef);
    pv[0] = s; p1[0] = e1; p0[0] = e0; pf[0] = ef; pt[0] = tag;
    stb = s; sw = uu;
    il = DW'(xi); vc = DW'(xv); vin = DW'(xin); ie = DW'(ri); ve = DW'(rv);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin pv[k] = 0; p1[k] = 0; p0[k] = 0; pf[k] = 0; pt[k] = ""; end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(vld == 1'b0, "R1 reset valid", longint'(vld), 0);
    chk(flag == 1'b0, "R1 reset flag", longint'(flag), 0);
    chk(s_on == 0 && s_off == 0, "R1 reset surfaces", longint'(s_on), 0);
    rst = 1'b0;
    idle(3);

    // R11: state at target, both control bits
    step(1, 0, 1200, 3000, 900, 1200, 3000, "R11 at target u0");
    step(1, 1, -700, 2500, 600, -700, 2500, "R11 at target u1");
    idle(3);
    chk(s_on == 0 && s_off == 0 && flag == 0, "R11 zero surfaces", longint'(s_on), 0);

    // R6: zero state isolates the penalty
    step(1, 0, 0, 0, 0, -500, -300, "R6 penalty only");
    idle(3);
    chk(s_on == s_off && s_on >= 0, "R6 equal nonneg", longint'(s_on), longint'(s_off));

    // R7: full-scale extremes, both control bits
    step(1, 0, 32767, 32767, 32767, -32768, -32768, "R7 full scale a u0");
    step(1, 1, 32767, 32767, 32767, -32768, -32768, "R7 full scale a u1");
    step(1, 0, -32768, 32767, -32768, 32767, -32768, "R7 full scale b u0");
    step(1, 1, -32768, 32767, -32768, 32767, -32768, "R7 full scale b u1");
    step(1, 1, 32767, -32768, 32767, -32768, 32767, "R7 full scale c u1");
    idle(4);

    // R8: same sample with each control bit, separated
    step(1, 0, 1500, -800, 1800, 200, 400, "R8 select off");
    idle(3);
    step(1, 1, 1500, -800, 1800, 200, 400, "R8 select on");
    idle(3);

    // R10: back-to-back burst
    for (int k = 0; k < 12; k++)
      step(1, k[0], longint'(k * 300 - 1500), longint'(2000 - k * 250), 1000,
           100, -200, "R10 burst");
    idle(4);

    // Random mix with gaps (R2, R3, R4, R5, R8, R9)
    for (int k = 0; k < 600; k++) begin
      bit s = ($urandom_range(0, 9) < 7);
      step(s, 1'($urandom_range(0, 1)),
           longint'($urandom_range(0, 4000)) - 2000, longint'($urandom_range(0, 4000)) - 2000,
           longint'($urandom_range(0, 4000)) - 2000, longint'($urandom_range(0, 4000)) - 2000,
           longint'($urandom_range(0, 4000)) - 2000, "random");
    end
    idle(5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_NS * 50000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule